// File: doc/BRIEF.md
# Block-Atomic DMA Bus Arbiter

This arbiter decides which of eight DMA channels owns the shared bus. A channel that has a block ready raises its request line. The arbiter grants the bus to one channel and keeps that grant for the whole burst block. A block is a power-of-two number of 32-bit words, and the channel gives its size exponent on a 4-bit field. The arbiter counts the words as they move on the bus. It flags the last word of the block. Then it releases the bus for one idle cycle before it picks the next owner.

Two configuration inputs control the arbiter. The mode bit selects fixed priority or round robin. In fixed mode the lowest-numbered requester wins. In round-robin mode the search starts at the channel after the one that last finished a block. The enable bit gates new grants only. A block that has already started always finishes, because a block is never split.

Top module: `dma_block_arbiter`

## Requirements
- R1: The `grant` output has at most one bit set in every cycle. Bit c set means channel c owns the bus.
- R2: With `rr_mode`=0, the arbiter grants the requesting channel with the lowest index. Channel 0 has the highest priority.
- R3: With `rr_mode`=1, the arbiter grants the first requesting channel found after the channel that most recently completed a block, going upward and wrapping from 7 to 0. After reset, the search starts at channel 0.
- R4: A block holds 2^x words. The value x is read from `blk_log2[4c+3:4c]` of the granted channel c when the grant is made. `block_done` is high in the same cycle as the 2^x-th `word_ack` of the block, and it is low at all other times.
- R5: Once a channel is granted, `grant` does not change until its `block_done`. Dropping `req`, clearing `global_en` or pausing `word_ack` has no effect on an ownership that is already in progress.
- R6: In the cycle after `block_done`, `grant` is all zero. A new grant appears no earlier than the cycle after that.
- R7: While `global_en` is 0, no new grant is issued from the idle state.
- R8: `word_ack` while no channel is granted is ignored. It does not count toward the next block.
- R9: `busy` is high exactly when some grant bit is set.
- R10: During reset and just after reset, `grant`, `busy` and `block_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| global_en | input | 1 | Allows new grants when 1 |
| rr_mode | input | 1 | Arbitration method: 0 fixed priority, 1 round robin |
| req | input | 8 | Block-ready request, one bit per channel |
| blk_log2 | input | 32 | Block size exponent, 4 bits per channel, channel c at bits 4c+3:4c |
| word_ack | input | 1 | One word of the owner's block moved on the bus this cycle |
| grant | output | 8 | One-hot bus ownership |
| block_done | output | 1 | The current word is the last word of the owner's block |
| busy | output | 1 | Some channel owns the bus |

## Verification
The assertions check four behaviours on every clock. The grant is one-hot or zero. The grant holds steady through a block. Each block is followed by an idle cycle. A grant is never issued from idle while disabled, and never to a channel that was not requesting.

Only the bench scenarios can show the rest. These are which channel wins under each mode, including the round-robin wrap from 7 to 0. They also include the exact word on which each block size ends, with and without stalls. Finally, the bench shows that acknowledges sent while the bus is idle are not counted toward the next block.

// File: rtl/dma_block_arbiter.sv
module dma_block_arbiter #(
  parameter int NUM_CH = 8,
  parameter int SZW    = 4,
  localparam int IDW   = $clog2(NUM_CH),
  localparam int CNTW  = (1 << SZW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  global_en,
  input  logic                  rr_mode,
  input  logic [NUM_CH-1:0]     req,
  input  logic [NUM_CH*SZW-1:0] blk_log2,
  input  logic                  word_ack,
  output logic [NUM_CH-1:0]     grant,
  output logic                  block_done,
  output logic                  busy
);

  logic [NUM_CH-1:0] grant_q;
  logic [IDW-1:0]    owner_q, last_q, pick, base;
  logic              pick_vld;
  logic [SZW-1:0]    lg_q;
  logic [CNTW-1:0]   cnt_q, lim;

  assign base = rr_mode ? last_q : IDW'(NUM_CH - 1);

  always_comb begin
    pick     = '0;
    pick_vld = 1'b0;
    for (int i = NUM_CH; i >= 1; i--) begin
      if (req[(int'(base) + i) % NUM_CH]) begin
        pick     = IDW'((int'(base) + i) % NUM_CH);
        pick_vld = 1'b1;
      end
    end
  end

  assign lim        = (CNTW'(1) << lg_q) - CNTW'(1);
  assign grant      = grant_q;
  assign busy       = |grant_q;
  assign block_done = busy & word_ack & (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      owner_q <= '0;
      last_q  <= IDW'(NUM_CH - 1);
      lg_q    <= '0;
      cnt_q   <= '0;
    end else if (!busy) begin
      if (global_en && pick_vld) begin
        grant_q <= NUM_CH'(1) << pick;
        owner_q <= pick;
        lg_q    <= blk_log2[pick*SZW +: SZW];
        cnt_q   <= '0;
      end
    end else if (word_ack) begin
      if (block_done) begin
        grant_q <= '0;
        last_q  <= owner_q;
      end else begin
        cnt_q <= cnt_q + CNTW'(1);
      end
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!busy || (grant & $past(req)) != '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !block_done) |=> $stable(grant));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> (grant == '0));

  p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !global_en) |=> !busy);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (grant != '0));

endmodule

// File: tb/dma_block_arbiter_bench.sv
`timescale 1ns/1ps
module dma_block_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        global_en = 1'b0;
  logic        rr_mode = 1'b0;
  logic [7:0]  req = '0;
  logic [31:0] blk_log2;
  logic        word_ack = 1'b0;
  logic [7:0]  grant;
  logic        block_done, busy;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dma_block_arbiter u_dma_block_arbiter (
    .clk(clk), .rst_n(rst_n), .global_en(global_en), .rr_mode(rr_mode),
    .req(req), .blk_log2(blk_log2), .word_ack(word_ack),
    .grant(grant), .block_done(block_done), .busy(busy)
  );

  // channel c uses exponent c mod 4: words 1,2,4,8
  initial for (int c = 0; c < 8; c++) blk_log2[4*c +: 4] = 4'(c % 4);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_grant(input int ch, input string tag);
    @(negedge clk); #1;
    check(grant == 8'(1 << ch), tag, grant, 1 << ch);
    check(busy == 1'b1, "R9 busy with grant", busy, 1);
  endtask

  task automatic finish_block(input int ch, input int n, input bit stall, input string tag);
    for (int k = 0; k < n; k++) begin
      word_ack = 1'b1; #1;
      check(block_done == (k == n - 1), {tag, " R4 done timing"}, block_done, k == n - 1);
      check(grant == 8'(1 << ch), {tag, " R5 held"}, grant, 1 << ch);
      @(negedge clk);
      if (stall && k < n - 1) begin
        word_ack = 1'b0; #1;
        check(grant == 8'(1 << ch) && !block_done, {tag, " R5 stall"}, grant, 1 << ch);
        @(negedge clk);
      end
    end
    word_ack = 1'b0; #1;
    check(grant == 8'h00, {tag, " R6 gap"}, grant, 0);
    check(busy == 1'b0, {tag, " R9 idle busy"}, busy, 0);
  endtask

  task automatic t_reset();
    global_en = 1'b1; req = 8'hff;
    @(negedge clk); #1;
    check(grant == 8'h00 && !busy && !block_done, "R10 in reset", grant, 0);
    req = 8'h00;
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(grant == 8'h00 && !busy, "R10 after reset", grant, 0);
  endtask

  task automatic t_fixed();
    rr_mode = 1'b0; global_en = 1'b1; req = 8'b1010_0100;
    expect_grant(2, "R2 lowest of 2,5,7");
    finish_block(2, 4, 1'b0, "ch2");
    expect_grant(2, "R2 ch2 again");
    finish_block(2, 4, 1'b1, "ch2 stalled");
    req = 8'b1010_0000;
    expect_grant(5, "R2 lowest of 5,7");
    finish_block(5, 2, 1'b0, "ch5");
    req = 8'h00;
  endtask

  task automatic t_round_robin();
    rr_mode = 1'b1; req = 8'b1010_0101;
    expect_grant(7, "R3 after last 5");
    finish_block(7, 8, 1'b0, "ch7");
    expect_grant(0, "R3 wrap to 0");
    finish_block(0, 1, 1'b0, "ch0");
    expect_grant(2, "R3 after 0");
    finish_block(2, 4, 1'b0, "ch2 rr");
    expect_grant(5, "R3 after 2");
    finish_block(5, 2, 1'b0, "ch5 rr");
    req = 8'h00;
  endtask

  task automatic t_enable();
    global_en = 1'b0; req = 8'h01;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(grant == 8'h00, "R7 disabled idle", grant, 0);
    end
    global_en = 1'b1;
    expect_grant(0, "R7 enable grants ch0");
    finish_block(0, 1, 1'b0, "ch0 en");
    req = 8'h80;
    expect_grant(7, "R3 ch7");
    global_en = 1'b0; req = 8'h00;
    finish_block(7, 8, 1'b1, "R5 ch7 enable dropped");
    @(negedge clk); #1;
    check(grant == 8'h00, "R7 stays idle after block", grant, 0);
  endtask

  task automatic t_idle_acks();
    global_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      word_ack = 1'b1;
      @(negedge clk); #1;
      check(grant == 8'h00 && !block_done, "R8 idle ack", block_done, 0);
    end
    word_ack = 1'b0; global_en = 1'b1; req = 8'h08;
    expect_grant(3, "R8 ch3 granted");
    req = 8'h00;
    finish_block(3, 8, 1'b0, "R8 full count");
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_round_robin();
    t_enable();
    t_idle_acks();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule